// File: doc/BRIEF.md
# Four-Channel Stereo Volume Mixer

This block combines four signed 16-bit sample streams into one stereo pair of 14-bit signed words. Every channel carries two volume codes, one for the left side and one for the right. On each sample strobe the mixer multiplies every channel's sample by the gain for each side, truncates each product to the 14-bit output scale, adds the four products per side in a wide accumulator and saturates the totals to the 14-bit range. A run mask gates each channel on its own, so a stopped channel adds nothing.

Volume codes are loaded through a two-step port. A select write picks a channel and a side, and a later value write stores a code into that selection. A flag marks each output sample that had to be clamped on either side. A sticky copy of that flag stays set until a clear pulse arrives.

Top module: `stereo_mix4`

## Requirements
- R1: For each side the output equals the sum over all four channels of floor(sample * gain / 1024), where sample is the channel's 16-bit signed lane of `smp_in` (channel n at bits 16n+15..16n) and gain is derived from that channel's code for that side.
- R2: A channel whose `ch_run` bit is 0 when the strobe is taken contributes zero to both sides.
- R3: Gain for code c in 0..28 is floor((256*c + 14) / 28). Code 0 mutes the channel and code 28 gives gain 256 (unity, a sample of 32767 alone yields 8191).
- R4: Codes 29, 30 and 31 behave exactly like code 28.
- R5: Left and right codes are held separately per channel, and writing one side leaves the other side unchanged.
- R6: A pulse on `vol_sel_we` stores `vol_ch` and `vol_side` (0 = left, 1 = right) as the target. A pulse on `vol_val_we` writes `vol_code` to the stored target. The target persists across value writes. A value write in the same cycle as a select write uses the previous target.
- R7: A side total above 8191 is output as 8191, and a total below -8192 is output as -8192.
- R8: `clip_now` is 1 for an output sample exactly when either side of that sample was saturated.
- R9: `clip_sticky` sets together with any clamped sample and holds until a `clr_clip` pulse. A clamp in the same cycle as a clear leaves it set.
- R10: Outputs load only on the clock edge that samples `smp_stb` high, so they appear one cycle after the strobe. `out_vld` pulses for that one cycle. Between strobes all outputs hold.
- R11: After reset both outputs are 0, all flags are 0, every volume code is 0 and the target is channel 0 left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | Sample strobe, one cycle |
| smp_in | input | 64 | Four 16-bit signed samples, channel 0 in the low lane |
| ch_run | input | 4 | Per-channel run mask |
| vol_sel_we | input | 1 | Latch channel and side as write target |
| vol_ch | input | 2 | Target channel for a select write |
| vol_side | input | 1 | Target side for a select write, 1 = right |
| vol_val_we | input | 1 | Write volume code to the latched target |
| vol_code | input | 5 | Volume code |
| clr_clip | input | 1 | Clear the sticky clamp flag |
| mix_l | output | 14 | Left mixed sample, signed |
| mix_r | output | 14 | Right mixed sample, signed |
| out_vld | output | 1 | New output sample this cycle |
| clip_now | output | 1 | Current output sample was clamped |
| clip_sticky | output | 1 | A clamp occurred since the last clear |

## Verification
The assertions check several rules on every cycle. Outputs hold unless a strobe came before. The valid pulse follows the strobe by one cycle. A clamped sample sits on a rail and always sets the sticky flag, which only falls after a clear. A strobe with every channel stopped yields silence. The arithmetic itself can only be shown by the bench's scenarios, which compare outputs against a model of the gain formula. These scenarios cover the gain values, high codes, separation of the left and right sides, persistence of the write target and positive and negative saturation.

// File: rtl/mix4_pkg.sv
package mix4_pkg;
  localparam int VOL_W     = 5;
  localparam int VOL_TOP   = 28;
  localparam int GAIN_FRAC = 8;
  localparam int GAIN_W    = GAIN_FRAC + 1;

  // Gain in Q.8 from a volume code; codes above the top step saturate.
  function automatic logic [GAIN_W-1:0] vol_gain(input logic [VOL_W-1:0] code);
    logic [VOL_W-1:0] c;
    logic [12:0]      num;
    logic [12:0]      q;
    c   = (code > VOL_W'(VOL_TOP)) ? VOL_W'(VOL_TOP) : code;
    num = ({8'd0, c} << GAIN_FRAC) + 13'(VOL_TOP / 2);
    q   = num / 13'(VOL_TOP);
    return q[GAIN_W-1:0];
  endfunction
endpackage

// File: rtl/mix4_volregs.sv
module mix4_volregs
  import mix4_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sel_we,
  input  logic [CHW-1:0]                sel_ch,
  input  logic                          sel_side,
  input  logic                          val_we,
  input  logic [VOL_W-1:0]              val_code,
  output logic [NCH-1:0][GAIN_W-1:0]    gain_l,
  output logic [NCH-1:0][GAIN_W-1:0]    gain_r
);
  logic [CHW-1:0]             tgt_ch_q, tgt_ch_d;
  logic                       tgt_side_q, tgt_side_d;
  logic [NCH-1:0][VOL_W-1:0]  code_l_q, code_l_d;
  logic [NCH-1:0][VOL_W-1:0]  code_r_q, code_r_d;

  always_comb begin
    tgt_ch_d   = tgt_ch_q;
    tgt_side_d = tgt_side_q;
    code_l_d   = code_l_q;
    code_r_d   = code_r_q;
    if (sel_we) begin
      tgt_ch_d   = sel_ch;
      tgt_side_d = sel_side;
    end
    if (val_we) begin
      if (tgt_side_q) code_r_d[tgt_ch_q] = val_code;
      else            code_l_d[tgt_ch_q] = val_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_ch_q   <= '0;
      tgt_side_q <= 1'b0;
      code_l_q   <= '0;
      code_r_q   <= '0;
    end else begin
      if (sel_we) begin
        tgt_ch_q   <= tgt_ch_d;
        tgt_side_q <= tgt_side_d;
      end
      if (val_we) begin
        code_l_q <= code_l_d;
        code_r_q <= code_r_d;
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_gain
    assign gain_l[g] = vol_gain(code_l_q[g]);
    assign gain_r[g] = vol_gain(code_r_q[g]);
  end
endmodule

// File: rtl/mix4_scale.sv
module mix4_scale
  import mix4_pkg::*;
#(
  parameter int SW = 16,
  parameter int OW = 14,
  localparam int PW    = SW + GAIN_W + 1,
  localparam int SHIFT = GAIN_FRAC + SW - OW
) (
  input  logic signed [SW-1:0] sample,
  input  logic                 run,
  input  logic [GAIN_W-1:0]    gain_l,
  input  logic [GAIN_W-1:0]    gain_r,
  output logic [OW-1:0]        part_l,
  output logic [OW-1:0]        part_r
);
  logic signed [PW-1:0] prod_l, prod_r;
  logic signed [PW-1:0] sh_l, sh_r;

  always_comb begin
    prod_l = sample * $signed({1'b0, gain_l});
    prod_r = sample * $signed({1'b0, gain_r});
    sh_l   = prod_l >>> SHIFT;
    sh_r   = prod_r >>> SHIFT;
    part_l = run ? sh_l[OW-1:0] : '0;
    part_r = run ? sh_r[OW-1:0] : '0;
  end
endmodule

// File: rtl/mix4_sum.sv
module mix4_sum #(
  parameter int NCH = 4,
  parameter int OW  = 14,
  localparam int AW = OW + $clog2(NCH) + 1
) (
  input  logic [NCH-1:0][OW-1:0] parts,
  output logic [OW-1:0]          sum_sat,
  output logic                   clipped
);
  localparam logic signed [AW-1:0] HI = AW'((1 << (OW - 1)) - 1);
  localparam logic signed [AW-1:0] LO = ~HI;

  logic signed [AW-1:0] acc;

  always_comb begin
    acc = '0;
    for (int i = 0; i < NCH; i++) begin
      acc = acc + $signed({{(AW-OW){parts[i][OW-1]}}, parts[i]});
    end
    clipped = 1'b1;
    if (acc > HI)      sum_sat = HI[OW-1:0];
    else if (acc < LO) sum_sat = LO[OW-1:0];
    else begin
      sum_sat = acc[OW-1:0];
      clipped = 1'b0;
    end
  end
endmodule

// File: rtl/stereo_mix4.sv
module stereo_mix4
  import mix4_pkg::*;
#(
  parameter int NCH = 4,
  parameter int SW  = 16,
  parameter int OW  = 14,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_stb,
  input  logic [NCH*SW-1:0]   smp_in,
  input  logic [NCH-1:0]      ch_run,
  input  logic                vol_sel_we,
  input  logic [CHW-1:0]      vol_ch,
  input  logic                vol_side,
  input  logic                vol_val_we,
  input  logic [VOL_W-1:0]    vol_code,
  input  logic                clr_clip,
  output logic [OW-1:0]       mix_l,
  output logic [OW-1:0]       mix_r,
  output logic                out_vld,
  output logic                clip_now,
  output logic                clip_sticky
);
  logic [NCH-1:0][GAIN_W-1:0] gain_l, gain_r;
  logic [NCH-1:0][OW-1:0]     part_l, part_r;
  logic [OW-1:0]              sat_l, sat_r;
  logic                       clip_l, clip_r;

  logic [OW-1:0] mix_l_d, mix_r_d;
  logic          clip_now_d, sticky_d;

  mix4_volregs #(.NCH(NCH)) u_vol (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_we   (vol_sel_we),
    .sel_ch   (vol_ch),
    .sel_side (vol_side),
    .val_we   (vol_val_we),
    .val_code (vol_code),
    .gain_l   (gain_l),
    .gain_r   (gain_r)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    mix4_scale #(.SW(SW), .OW(OW)) u_scale (
      .sample (smp_in[g*SW +: SW]),
      .run    (ch_run[g]),
      .gain_l (gain_l[g]),
      .gain_r (gain_r[g]),
      .part_l (part_l[g]),
      .part_r (part_r[g])
    );
  end

  mix4_sum #(.NCH(NCH), .OW(OW)) u_sum_l (
    .parts (part_l), .sum_sat (sat_l), .clipped (clip_l)
  );
  mix4_sum #(.NCH(NCH), .OW(OW)) u_sum_r (
    .parts (part_r), .sum_sat (sat_r), .clipped (clip_r)
  );

  always_comb begin
    mix_l_d    = smp_stb ? sat_l : mix_l;
    mix_r_d    = smp_stb ? sat_r : mix_r;
    clip_now_d = smp_stb ? (clip_l | clip_r) : clip_now;
    sticky_d   = (smp_stb & (clip_l | clip_r)) | (clip_sticky & ~clr_clip);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mix_l       <= '0;
      mix_r       <= '0;
      clip_now    <= 1'b0;
      out_vld     <= 1'b0;
      clip_sticky <= 1'b0;
    end else begin
      out_vld     <= smp_stb;
      clip_sticky <= sticky_d;
      if (smp_stb) begin
        mix_l    <= mix_l_d;
        mix_r    <= mix_r_d;
        clip_now <= clip_now_d;
      end
    end
  end
endmodule

// File: rtl/mix4_chk.sv
module mix4_chk #(
  parameter int NCH = 4,
  parameter int OW  = 14
) (
  input logic           clk,
  input logic           rst_n,
  input logic           smp_stb,
  input logic [NCH-1:0] ch_run,
  input logic           clr_clip,
  input logic [OW-1:0]  mix_l,
  input logic [OW-1:0]  mix_r,
  input logic           out_vld,
  input logic           clip_now,
  input logic           clip_sticky
);
  localparam logic [OW-1:0] RAIL_HI = {1'b0, {(OW-1){1'b1}}};
  localparam logic [OW-1:0] RAIL_LO = {1'b1, {(OW-1){1'b0}}};

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(smp_stb) |-> ($stable(mix_l) && $stable(mix_r)));

  a_r10_vld: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld == $past(smp_stb));

  a_r8_rail: assert property (@(posedge clk) disable iff (!rst_n)
    clip_now |-> (mix_l == RAIL_HI || mix_l == RAIL_LO ||
                  mix_r == RAIL_HI || mix_r == RAIL_LO));

  a_r9_set: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && clip_now) |-> clip_sticky);

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clip_sticky) |-> $past(clr_clip));

  a_r2_silent: assert property (@(posedge clk) disable iff (!rst_n)
    $past(smp_stb && (ch_run == '0)) |-> (mix_l == '0 && mix_r == '0));
endmodule

bind stereo_mix4 mix4_chk #(.NCH(NCH), .OW(OW)) u_mix4_chk (.*);

// File: tb/tb_stereo_mix4.sv
module tb_stereo_mix4;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_stb, vol_sel_we, vol_side, vol_val_we, clr_clip;
  logic [63:0] smp_in;
  logic [3:0]  ch_run;
  logic [1:0]  vol_ch;
  logic [4:0]  vol_code;
  logic [13:0] mix_l, mix_r;
  logic        out_vld, clip_now, clip_sticky;

  int checks = 0;
  int errors = 0;
  int smp [4];
  int vl [4];
  int vr [4];

  always #5 clk = ~clk;

  stereo_mix4 dut (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int gain_of(input int code);
    int c = (code > 28) ? 28 : code;
    return (256 * c + 14) / 28;
  endfunction

  function automatic int model(input bit right, input logic [3:0] run);
    int acc = 0;
    for (int i = 0; i < 4; i++) begin
      int p;
      if (!run[i]) continue;
      p = smp[i] * gain_of(right ? vr[i] : vl[i]);
      acc += p >>> 10;
    end
    if (acc > 8191) acc = 8191;
    if (acc < -8192) acc = -8192;
    return acc;
  endfunction

  function automatic bit model_clip(input logic [3:0] run);
    int al = 0, ar = 0;
    for (int i = 0; i < 4; i++) begin
      if (!run[i]) continue;
      al += (smp[i] * gain_of(vl[i])) >>> 10;
      ar += (smp[i] * gain_of(vr[i])) >>> 10;
    end
    return (al > 8191 || al < -8192 || ar > 8191 || ar < -8192);
  endfunction

  task automatic set_vol(input int ch, input bit side, input int code);
    @(negedge clk);
    vol_sel_we = 1'b1; vol_ch = 2'(ch); vol_side = side;
    @(negedge clk);
    vol_sel_we = 1'b0; vol_val_we = 1'b1; vol_code = 5'(code);
    @(negedge clk);
    vol_val_we = 1'b0;
    if (side) vr[ch] = code; else vl[ch] = code;
  endtask

  task automatic strobe(input int s0, input int s1, input int s2, input int s3);
    smp[0] = s0; smp[1] = s1; smp[2] = s2; smp[3] = s3;
    @(negedge clk);
    smp_in = {16'(s3), 16'(s2), 16'(s1), 16'(s0)};
    smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0;
  endtask

  task automatic check_mix(input string req);
    check({req, " left"},  $signed(mix_l), model(1'b0, ch_run));
    check({req, " right"}, $signed(mix_r), model(1'b1, ch_run));
    check({req, " clip_now"}, int'(clip_now), int'(model_clip(ch_run)));
    check({req, " out_vld"}, int'(out_vld), 1);
  endtask

  task automatic t_reset();
    check("R11 left", $signed(mix_l), 0);
    check("R11 right", $signed(mix_r), 0);
    check("R11 flags", int'({out_vld, clip_now, clip_sticky}), 0);
    ch_run = 4'hF;
    strobe(20000, -20000, 12345, 7);
    check("R11 volumes muted left", $signed(mix_l), 0);
    check("R11 volumes muted right", $signed(mix_r), 0);
  endtask

  task automatic t_unity();
    ch_run = 4'b0001;
    set_vol(0, 1'b0, 28);
    set_vol(0, 1'b1, 28);
    strobe(32767, 0, 0, 0);
    check("R3 unity left", $signed(mix_l), 8191);
    strobe(-1000, 0, 0, 0);
    check_mix("R3 negative unity");
  endtask

  task automatic t_steps();
    ch_run = 4'b0001;
    for (int c = 1; c <= 28; c += 9) begin
      set_vol(0, 1'b0, c);
      strobe(30001, 0, 0, 0);
      check_mix("R3 step");
    end
  endtask

  task automatic t_mix4();
    ch_run = 4'hF;
    set_vol(1, 1'b0, 14); set_vol(2, 1'b0, 7); set_vol(3, 1'b0, 20);
    set_vol(1, 1'b1, 3);  set_vol(2, 1'b1, 27); set_vol(3, 1'b1, 1);
    set_vol(0, 1'b0, 28);
    strobe(1000, -2000, 3000, -4000);
    check_mix("R1 four channel");
    strobe(-17, 31111, -9999, 255);
    check_mix("R1 second pattern");
  endtask

  task automatic t_gate();
    ch_run = 4'b1010;
    strobe(1000, -2000, 3000, -4000);
    check_mix("R2 partial gate");
    ch_run = 4'b0000;
    strobe(30000, 30000, 30000, 30000);
    check("R2 all stopped left", $signed(mix_l), 0);
    check("R2 all stopped right", $signed(mix_r), 0);
    ch_run = 4'hF;
  endtask

  task automatic t_high_code();
    ch_run = 4'b0100;
    set_vol(2, 1'b0, 31);
    set_vol(2, 1'b1, 29);
    strobe(0, 0, 32767, 0);
    check("R4 code 31 left", $signed(mix_l), 8191);
    check("R4 code 29 right", $signed(mix_r), 8191);
  endtask

  task automatic t_sides();
    ch_run = 4'b1000;
    set_vol(3, 1'b1, 0);
    set_vol(3, 1'b0, 28);
    strobe(0, 0, 0, 4000);
    check("R5 left set", $signed(mix_l), 1000);
    check("R5 right untouched", $signed(mix_r), 0);
  endtask

  task automatic t_target();
    ch_run = 4'b0010;
    set_vol(1, 1'b1, 5);
    @(negedge clk);
    vol_val_we = 1'b1; vol_code = 5'd28;
    @(negedge clk);
    vol_val_we = 1'b0;
    vr[1] = 28;
    strobe(0, 8000, 0, 0);
    check("R6 target persists right", $signed(mix_r), 2000);
    check("R6 other side kept", $signed(mix_l), model(1'b0, ch_run));
    @(negedge clk);
    vol_sel_we = 1'b1; vol_ch = 2'd0; vol_side = 1'b1;
    vol_val_we = 1'b1; vol_code = 5'd0;
    @(negedge clk);
    vol_sel_we = 1'b0; vol_val_we = 1'b0;
    vr[1] = 0;
    strobe(0, 8000, 0, 0);
    check("R6 same-cycle uses old target", $signed(mix_r), 0);
  endtask

  task automatic t_clamp();
    ch_run = 4'hF;
    for (int i = 0; i < 4; i++) begin
      set_vol(i, 1'b0, 28);
      set_vol(i, 1'b1, 28);
    end
    strobe(32767, 32767, 32767, 32767);
    check("R7 high rail", $signed(mix_l), 8191);
    check("R8 clip_now high", int'(clip_now), 1);
    check("R9 sticky set", int'(clip_sticky), 1);
    strobe(-32768, -32768, -32768, -32768);
    check("R7 low rail", $signed(mix_r), -8192);
    strobe(100, 100, 100, 100);
    check_mix("R8 no clamp");
    check("R9 sticky held", int'(clip_sticky), 1);
    @(negedge clk); clr_clip = 1'b1;
    @(negedge clk); clr_clip = 1'b0;
    check("R9 cleared", int'(clip_sticky), 0);
    @(negedge clk);
    smp_in = {4{16'sd32767}}; smp_stb = 1'b1; clr_clip = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0; clr_clip = 1'b0;
    check("R9 set beats clear", int'(clip_sticky), 1);
  endtask

  task automatic t_hold();
    int l0, r0;
    ch_run = 4'hF;
    strobe(500, 600, -700, 800);
    l0 = $signed(mix_l); r0 = $signed(mix_r);
    smp_in = {4{16'sd20000}};
    repeat (4) @(negedge clk);
    check("R10 hold left", $signed(mix_l), l0);
    check("R10 hold right", $signed(mix_r), r0);
    check("R10 vld low", int'(out_vld), 0);
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL R10 watchdog: act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    smp_stb = 1'b0; vol_sel_we = 1'b0; vol_side = 1'b0; vol_val_we = 1'b0;
    clr_clip = 1'b0; smp_in = '0; ch_run = '0; vol_ch = '0; vol_code = '0;
    for (int i = 0; i < 4; i++) begin vl[i] = 0; vr[i] = 0; smp[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unity();
    t_steps();
    t_mix4();
    t_gate();
    t_high_code();
    t_sides();
    t_target();
    t_clamp();
    t_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule